// File: doc/BRIEF.md
# Power-fail write-protect sequencer

This block supervises a battery-backed static memory. It takes three digitised supply-monitor flags and derives from them the memory's write protection, its data-bus drive and its power source. The three flags are: supply above the trip level, supply above the switchover level, and supply above the seal-arming level. Each flag passes through a two-flop synchronizer and a debounce filter. A five-state machine then acts on the filtered flags. The host's chip, write and output enables pass to the memory only while the machine is in normal operation. In every other state they are forced inactive and the data outputs are held high-impedance.

The states and their transitions are as follows:

- **SEALED** is the reset state. The battery path is disconnected, and a supply loss here retains nothing. The first time the seal-arming flag qualifies, the seal is broken and the machine moves to **PROTECTED**. It never returns to SEALED after that.
- **PROTECTED** moves to **BATTERY** when the switchover flag drops. This check takes priority. Otherwise it moves to **RECOVERY** when the trip flag is valid.
- **BATTERY** selects the battery. It moves back to PROTECTED when the switchover flag returns.
- **RECOVERY** counts the 125 ms qualification window, derived from `CLK_FREQ_HZ`, and then moves to **NORMAL**. If the trip flag drops during the count, it moves back to PROTECTED, and the count starts again on the next entry.
- **NORMAL** moves to PROTECTED as soon as the filtered trip flag drops.

Top module: `pwr_guard_seq`

## Requirements
- R1: During and right after reset the state is SEALED: `wr_protect`=1, `bat_sel`=0, `bat_en`=0, all three memory enables high, `dq_drive`=0.
- R2: A raw flag change reaches the state machine only after the synchronised value has differed from the filtered value for `DEB_CYCLES` consecutive clocks. A pulse of `DEB_CYCLES`-1 clocks or fewer has no effect on any output.
- R3: The machine leaves SEALED only on a qualified seal-arming flag. From then on `bat_en` stays 1 until reset.
- R4: While SEALED, a qualified loss of the switchover flag leaves `bat_sel` at 0.
- R5: In NORMAL, a raw trip flag drop raises `wr_protect` no later than `DEB_CYCLES`+3 clocks after it is sampled.
- R6: While `wr_protect`=1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1 and `dq_drive` is 0, whatever the host drives.
- R7: In NORMAL, the memory enables equal the host enables. `dq_drive` is 1 exactly when the host chip enable is low, the output enable is low and the write enable is high.
- R8: PROTECTED moves to BATTERY (`bat_sel`=1) on a qualified switchover loss. It returns to PROTECTED (`bat_sel`=0) when the switchover flag returns.
- R9: From PROTECTED with a valid trip flag, `wr_protect` stays 1 for exactly `CLK_FREQ_HZ`/1000*`RECOVER_MS` clocks in RECOVERY, then falls in NORMAL.
- R10: A qualified trip-flag drop during RECOVERY goes back to PROTECTED, and the next recovery window starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | free-running clock |
| rst_n | input | 1 | asynchronous active-low reset (first power-up of the supervisor) |
| vtrip_raw | input | 1 | supply above trip level, unsynchronised |
| vswitch_raw | input | 1 | supply above switchover level, unsynchronised |
| vseal_raw | input | 1 | supply above seal-arming level, unsynchronised |
| host_ce_n | input | 1 | host chip enable, active low |
| host_we_n | input | 1 | host write enable, active low |
| host_oe_n | input | 1 | host output enable, active low |
| mem_ce_n | output | 1 | gated chip enable to the memory |
| mem_we_n | output | 1 | gated write enable to the memory |
| mem_oe_n | output | 1 | gated output enable to the memory |
| dq_drive | output | 1 | data output drivers enabled (0 = high-impedance) |
| wr_protect | output | 1 | write protection active |
| bat_sel | output | 1 | memory supply taken from the battery |
| bat_en | output | 1 | battery path armed (seal broken) |

## Verification
The supply flags are stepped through several sequences, each chosen to tell one behaviour apart from its neighbours:

- A switchover loss before the seal is broken: a wrong battery switch appears only here.
- A sub-threshold glitch on the seal flag and on the trip flag: this separates a working debounce from a pass-through.
- A full recovery: this pins the exact length of the window.
- A dip in the middle of recovery: this shows whether the count restarts or resumes.
- A full drop to battery and back.

Throughout every sequence, the host enables are driven with random values each cycle. This exposes gating that leaks in a protected state, and a wrong drive condition in NORMAL.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

    typedef enum logic [2:0] {
        ST_SEALED  = 3'd0,
        ST_PROTECT = 3'd1,
        ST_BATTERY = 3'd2,
        ST_RECOVER = 3'd3,
        ST_NORMAL  = 3'd4
    } guard_state_t;

    localparam int NUM_FLAGS   = 3;
    localparam int FLAG_TRIP   = 0;
    localparam int FLAG_SWITCH = 1;
    localparam int FLAG_SEAL   = 2;

endpackage

// File: rtl/pwr_flag_filter.sv
module pwr_flag_filter #(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic filt_out
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

    logic          sync_a;
    logic          sync_b;
    logic          held;
    logic [CW-1:0] cnt;

    // two-flop synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= raw_in;
            sync_b <= sync_a;
        end
    end

    // debounce: accept a new level after DEB_CYCLES consecutive disagreements
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= 1'b0;
            cnt  <= '0;
        end else if (sync_b != held) begin
            if (cnt == CNT_LAST) begin
                held <= sync_b;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

    assign filt_out = held;

    // R2
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_b == held) |=> $stable(held));

    // R2
    filt_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= CNT_LAST));

endmodule

// File: rtl/pwr_guard_fsm.sv
module pwr_guard_fsm
    import pwr_guard_pkg::*;
#(
    parameter int unsigned REC_CYCLES = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trip_ok,
    input  logic         switch_ok,
    input  logic         seal_ok,
    output guard_state_t state
);
    localparam int RW = $clog2(REC_CYCLES + 1);
    localparam logic [RW-1:0] REC_LAST = RW'(REC_CYCLES - 1);

    guard_state_t  state_q;
    guard_state_t  state_d;
    logic [RW-1:0] rec_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEALED;
        else        state_q <= state_d;
    end

    // recovery qualification counter: runs only while recovering on a valid supply
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                rec_cnt <= '0;
        else if (state_q == ST_RECOVER && trip_ok) rec_cnt <= rec_cnt + 1'b1;
        else                                       rec_cnt <= '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEALED:  if (seal_ok) state_d = ST_PROTECT;
            ST_PROTECT: begin
                if (!switch_ok)   state_d = ST_BATTERY;
                else if (trip_ok) state_d = ST_RECOVER;
            end
            ST_BATTERY: if (switch_ok) state_d = ST_PROTECT;
            ST_RECOVER: begin
                if (!trip_ok)                 state_d = ST_PROTECT;
                else if (rec_cnt == REC_LAST) state_d = ST_NORMAL;
            end
            ST_NORMAL:  if (!trip_ok) state_d = ST_PROTECT;
            default:    state_d = ST_SEALED;
        endcase
    end

    assign state = state_q;

    // R3
    seal_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEALED && !seal_ok) |=> (state_q == ST_SEALED));

    // R3
    seal_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SEALED) |=> (state_q != ST_SEALED));

    // R5
    norm_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && !trip_ok) |=> (state_q == ST_PROTECT));

    // R8
    bat_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROTECT && !switch_ok) |=> (state_q == ST_BATTERY));

    // R9
    norm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RECOVER && state_q != ST_NORMAL) |=> (state_q != ST_NORMAL));

    // R10
    rec_dip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && !trip_ok) |=> (state_q == ST_PROTECT && rec_cnt == '0));

endmodule

// File: rtl/pwr_bus_gate.sv
module pwr_bus_gate
    import pwr_guard_pkg::*;
(
    input  guard_state_t state,
    input  logic         host_ce_n,
    input  logic         host_we_n,
    input  logic         host_oe_n,
    output logic         mem_ce_n,
    output logic         mem_we_n,
    output logic         mem_oe_n,
    output logic         dq_drive,
    output logic         wr_protect,
    output logic         bat_sel,
    output logic         bat_en
);
    always_comb begin
        wr_protect = 1'b1;
        bat_sel    = 1'b0;
        bat_en     = 1'b1;
        unique case (state)
            ST_SEALED:  bat_en     = 1'b0;
            ST_PROTECT: wr_protect = 1'b1;
            ST_BATTERY: bat_sel    = 1'b1;
            ST_RECOVER: wr_protect = 1'b1;
            ST_NORMAL:  wr_protect = 1'b0;
            default:    bat_en     = 1'b0;
        endcase
        mem_ce_n = host_ce_n | wr_protect;
        mem_we_n = host_we_n | wr_protect;
        mem_oe_n = host_oe_n | wr_protect;
        dq_drive = ~mem_ce_n & ~mem_oe_n & host_we_n;
    end

endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq
    import pwr_guard_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 50_000_000,
    parameter int unsigned RECOVER_MS  = 125,
    parameter int          DEB_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vtrip_raw,
    input  logic vswitch_raw,
    input  logic vseal_raw,
    input  logic host_ce_n,
    input  logic host_we_n,
    input  logic host_oe_n,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic mem_oe_n,
    output logic dq_drive,
    output logic wr_protect,
    output logic bat_sel,
    output logic bat_en
);
    localparam int unsigned REC_CYCLES = (CLK_FREQ_HZ / 1000) * RECOVER_MS;

    logic [NUM_FLAGS-1:0] raw_flags;
    logic [NUM_FLAGS-1:0] ok_flags;
    guard_state_t         state;

    assign raw_flags[FLAG_TRIP]   = vtrip_raw;
    assign raw_flags[FLAG_SWITCH] = vswitch_raw;
    assign raw_flags[FLAG_SEAL]   = vseal_raw;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_filt
        pwr_flag_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (raw_flags[g]),
            .filt_out (ok_flags[g])
        );
    end

    pwr_guard_fsm #(.REC_CYCLES(REC_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_ok   (ok_flags[FLAG_TRIP]),
        .switch_ok (ok_flags[FLAG_SWITCH]),
        .seal_ok   (ok_flags[FLAG_SEAL]),
        .state     (state)
    );

    pwr_bus_gate u_gate (
        .state      (state),
        .host_ce_n  (host_ce_n),
        .host_we_n  (host_we_n),
        .host_oe_n  (host_oe_n),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .dq_drive   (dq_drive),
        .wr_protect (wr_protect),
        .bat_sel    (bat_sel),
        .bat_en     (bat_en)
    );

    // R4
    sealed_nobat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bat_en) |-> (!bat_sel));

    // R6
    prot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_NORMAL) |-> (mem_we_n && mem_ce_n && !dq_drive));

    // R8
    bat_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_sel && ok_flags[FLAG_SWITCH]) |=> (!bat_sel && wr_protect));

endmodule

// File: tb/pwr_guard_seq_tb.sv
module pwr_guard_seq_tb;
    localparam int unsigned FREQ = 8000;
    localparam int unsigned RMS  = 125;
    localparam int          DEB  = 4;
    localparam int          REC  = (FREQ / 1000) * RMS;

    localparam int M_SEAL = 0, M_PROT = 1, M_BAT = 2, M_REC = 3, M_NORM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vtrip = 1'b0, vswitch = 1'b0, vseal = 1'b0;
    logic hce = 1'b1, hwe = 1'b1, hoe = 1'b1;
    logic mce, mwe, moe, dqd, wp, bsel, ben;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    pwr_guard_seq #(.CLK_FREQ_HZ(FREQ), .RECOVER_MS(RMS), .DEB_CYCLES(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .vtrip_raw(vtrip), .vswitch_raw(vswitch), .vseal_raw(vseal),
        .host_ce_n(hce), .host_we_n(hwe), .host_oe_n(hoe),
        .mem_ce_n(mce), .mem_we_n(mwe), .mem_oe_n(moe), .dq_drive(dqd),
        .wr_protect(wp), .bat_sel(bsel), .bat_en(ben)
    );

    // behavioural reference: delayed samples, run-length debounce, state walk
    int m_st = M_SEAL;
    int rc = 0;
    int dly1[3], dly2[3], run[3], filt[3];

    always @(posedge clk) begin
        int raw[3];
        int tap[3];
        raw[0] = int'(vtrip); raw[1] = int'(vswitch); raw[2] = int'(vseal);
        if (!rst_n) begin
            m_st = M_SEAL; rc = 0;
            for (int i = 0; i < 3; i++) begin
                dly1[i] = 0; dly2[i] = 0; run[i] = 0; filt[i] = 0;
            end
        end else begin
            case (m_st)
                M_SEAL: if (filt[2] == 1) m_st = M_PROT;
                M_PROT: begin
                    if (filt[1] == 0)      m_st = M_BAT;
                    else if (filt[0] == 1) begin m_st = M_REC; rc = 0; end
                end
                M_BAT:  if (filt[1] == 1) m_st = M_PROT;
                M_REC: begin
                    if (filt[0] == 0) m_st = M_PROT;
                    else begin
                        rc++;
                        if (rc == REC) m_st = M_NORM;
                    end
                end
                default: if (filt[0] == 0) m_st = M_PROT;
            endcase
            for (int i = 0; i < 3; i++) begin
                tap[i] = dly2[i];
                dly2[i] = dly1[i];
                dly1[i] = raw[i];
                if (tap[i] != filt[i]) begin
                    run[i]++;
                    if (run[i] == DEB) begin filt[i] = tap[i]; run[i] = 0; end
                end else run[i] = 0;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done && cyc > 0) begin
            logic e_wp, e_ce, e_we, e_oe, e_dq;
            logic [6:0] act, exp_v;
            e_wp = (m_st != M_NORM);
            e_ce = hce | e_wp;
            e_we = hwe | e_wp;
            e_oe = hoe | e_wp;
            e_dq = !e_ce && !e_oe && hwe;
            exp_v = {e_wp, logic'(m_st == M_BAT), logic'(m_st != M_SEAL), e_ce, e_we, e_oe, e_dq};
            act   = {wp, bsel, ben, mce, mwe, moe, dqd};
            n_cmp++;
            if (act !== exp_v) begin
                n_bad++;
                $display("FAIL %s cycle %0d: {wp,bsel,ben,ce,we,oe,dq} actual %b expected %b",
                         cur_req, cyc, act, exp_v);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
            {hce, hwe, hoe} = 3'($urandom);
        end
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp_v);
        end
    endtask

    initial begin
        step(5);
        // R1 reset state
        chk("R1", "wr_protect", wp, 1'b1);
        chk("R1", "bat_sel", bsel, 1'b0);
        chk("R1", "bat_en", ben, 1'b0);
        chk("R1", "dq_drive", dqd, 1'b0);
        rst_n = 1'b1;
        step(3);
        chk("R1", "bat_en after release", ben, 1'b0);

        cur_req = "R4";
        vswitch = 1'b1; step(20);
        vswitch = 1'b0; step(20);
        chk("R4", "bat_sel sealed loss", bsel, 1'b0);

        cur_req = "R2";
        vseal = 1'b1; step(DEB - 1);
        vseal = 1'b0; step(20);
        chk("R2", "seal glitch ignored", ben, 1'b0);

        cur_req = "R3";
        vswitch = 1'b1; vseal = 1'b1; step(20);
        chk("R3", "bat_en armed", ben, 1'b1);
        chk("R3", "still protected", wp, 1'b1);

        cur_req = "R9";
        vtrip = 1'b1; step(2 + DEB + 1 + REC - 1);
        chk("R9", "protected one cycle before release", wp, 1'b1);
        step(1);
        chk("R9", "released after window", wp, 1'b0);

        cur_req = "R7";
        step(200);

        cur_req = "R2";
        vtrip = 1'b0; step(DEB - 1);
        vtrip = 1'b1; step(20);
        chk("R2", "trip glitch ignored", wp, 1'b0);

        cur_req = "R5";
        vtrip = 1'b0; step(DEB + 3);
        chk("R5", "protect latency", wp, 1'b1);

        cur_req = "R6";
        step(100);

        cur_req = "R10";
        vtrip = 1'b1; step(500);
        vtrip = 1'b0; step(20);
        vtrip = 1'b1; step(600);
        chk("R10", "window restarted", wp, 1'b1);
        step(500);
        chk("R10", "released after full window", wp, 1'b0);

        cur_req = "R8";
        vtrip = 1'b0; step(20);
        vswitch = 1'b0; vseal = 1'b0; step(20);
        chk("R8", "battery selected", bsel, 1'b1);
        step(50);
        vswitch = 1'b1; step(20);
        chk("R8", "battery released", bsel, 1'b0);
        chk("R8", "protected after battery", wp, 1'b1);

        cur_req = "R9";
        vseal = 1'b1; vtrip = 1'b1; step(REC + 30);
        chk("R9", "normal after second window", wp, 1'b0);

        cur_req = "R3";
        chk("R3", "bat_en kept", ben, 1'b1);
        step(5);
        finish_run();
    end

endmodule